// File: doc/BRIEF.md
# Reference-Window Oscillator Trim Controller

This block keeps an on-chip oscillator near its target frequency. It compares the system clock against a slow, independent reference clock and moves a 6-bit trim code one step at a time. The reference input goes through a synchronizer, and its rising edges are counted in the system-clock domain. A measurement window spans a fixed number of reference periods, `REF_EDGES`. While the window is open, a second counter totals the system-clock cycles. When the window closes, that total is compared with a programmed expected count, inside a programmable dead band. The trim code then steps down if the clock runs fast, steps up if it runs slow, or stays where it is.

After each change of the trim code, the next window is measured and reported but does not trigger an adjustment. This gives the oscillator time to settle, because nothing signals when its frequency shift is complete. Each completed window raises a one-cycle strobe. The strobe comes with the measured count and flags that show which way the code moved. The trim code has no effect on the reference clock path. Clearing the enable stops measurement and holds the trim code.

Top module: `osc_trim_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, trim_o equals TRIM_RST (default 32), and done_o, up_o, down_o and meas_o are all zero.
- R2: The count reported on meas_o with each done_o strobe equals the number of system-clock cycles between the reference rising edge that opened the window and the edge that closed it. That edge is REF_EDGES reference periods later (default 4).
- R3: If the count is greater than expect_i + tol_i and no settle window is pending, trim_o decreases by one and down_o is high with the strobe.
- R4: If count + tol_i is less than expect_i and no settle window is pending, trim_o increases by one and up_o is high with the strobe.
- R5: A count that lies within tol_i of expect_i, with the bounds counted as inside, leaves trim_o unchanged with up_o and down_o both low.
- R6: trim_o never moves below 0 or above 63. An adjustment that would cross a limit leaves the code unchanged, raises no flag and starts no settle window.
- R7: The window that completes after a change of trim_o is reported on meas_o with done_o, but it produces no adjustment and no flag. The window after it is evaluated normally.
- R8: done_o is high for exactly one cycle per window. up_o and down_o are high only together with done_o and never at the same time.
- R9: The done_o strobe appears on the third rising system-clock edge after a rising edge of ref_clk_i that closes a window.
- R10: While en_i is low, done_o stays low and trim_o is held, and any pending settle window is cancelled. After en_i rises, the first reference rising edge only opens a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the clock being trimmed |
| rst_n | input | 1 | Active-low reset, asynchronous assert, release synchronous to clk |
| en_i | input | 1 | Measurement and adjustment enable |
| ref_clk_i | input | 1 | Asynchronous slow reference clock |
| expect_i | input | CNT_W | Expected system-clock cycles per window |
| tol_i | input | CNT_W | Half-width of the dead band around expect_i |
| trim_o | output | TRIM_W | Oscillator trim code |
| done_o | output | 1 | One-cycle strobe for each completed window |
| up_o | output | 1 | Trim code was incremented with this strobe |
| down_o | output | 1 | Trim code was decremented with this strobe |
| meas_o | output | CNT_W | Count measured in the last completed window |

## Verification
A rising edge on the reference input reaches the edge detector after two synchronizer flops. Every result of a window (done_o, up_o, down_o, trim_o and meas_o) is then registered together on the third rising clock edge after that reference edge. The bench drives all inputs on falling edges and polls done_o on falling edges. It reads the flags, the trim code and the count in the half cycle where done_o is first seen high, and confirms on the next falling edge that the strobe has dropped. A directed test steps the reference input by hand and samples done_o on each of the three falling edges that follow the closing reference edge. done_o must be low on the first two and high on the third.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_HOLD = 2'd0,
    TRIM_UP   = 2'd1,
    TRIM_DOWN = 2'd2
  } trim_dir_e;
endpackage

// File: rtl/ots_ref_sync.sv
module ots_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async_i,
  output logic ref_rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= ref_async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ref_rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/ots_window.sv
module ots_window #(
  parameter int CNT_W     = 16,
  parameter int REF_EDGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ref_rise_i,
  output logic             win_end_o,
  output logic [CNT_W-1:0] win_cnt_o
);
  localparam int EDGE_W = (REF_EDGES > 1) ? $clog2(REF_EDGES) : 1;
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(REF_EDGES - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic              armed_q, armed_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              state_en;

  // saturating increment of the system-cycle count
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_comb begin
    armed_d   = armed_q;
    edge_d    = edge_q;
    cnt_d     = cnt_q;
    win_end_o = 1'b0;
    if (!en_i) begin
      armed_d = 1'b0;
      edge_d  = '0;
      cnt_d   = '0;
    end else if (ref_rise_i) begin
      if (!armed_q) begin
        armed_d = 1'b1;
        edge_d  = '0;
        cnt_d   = '0;
      end else if (edge_q == EDGE_LAST) begin
        win_end_o = 1'b1;
        edge_d    = '0;
        cnt_d     = '0;
      end else begin
        edge_d = edge_q + 1'b1;
        cnt_d  = cnt_inc;
      end
    end else if (armed_q) begin
      cnt_d = cnt_inc;
    end
  end

  assign state_en = !en_i || ref_rise_i || armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      edge_q  <= '0;
      cnt_q   <= '0;
    end else if (state_en) begin
      armed_q <= armed_d;
      edge_q  <= edge_d;
      cnt_q   <= cnt_d;
    end
  end

  // count including the closing cycle
  assign win_cnt_o = cnt_inc;
endmodule

// File: rtl/ots_trim_ctl.sv
module ots_trim_ctl
  import osc_trim_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TRIM_W   = 6,
  parameter int TRIM_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              win_end_i,
  input  logic [CNT_W-1:0]  win_cnt_i,
  input  logic [CNT_W-1:0]  expect_i,
  input  logic [CNT_W-1:0]  tol_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              done_o,
  output logic              up_o,
  output logic              down_o,
  output logic [CNT_W-1:0]  meas_o
);
  localparam logic [TRIM_W-1:0] TRIM_MAX  = '1;
  localparam logic [TRIM_W-1:0] TRIM_INIT = TRIM_W'(TRIM_RST);

  logic [TRIM_W-1:0] trim_q, trim_d;
  logic              skip_q, skip_d;
  logic              done_q, up_q, down_q;
  logic [CNT_W-1:0]  meas_q;
  logic [CNT_W:0]    hi_lim, lo_sum;
  logic              too_fast, too_slow;
  trim_dir_e         dir;

  assign hi_lim   = {1'b0, expect_i} + {1'b0, tol_i};
  assign lo_sum   = {1'b0, win_cnt_i} + {1'b0, tol_i};
  assign too_fast = {1'b0, win_cnt_i} > hi_lim;
  assign too_slow = lo_sum < {1'b0, expect_i};

  always_comb begin
    dir = TRIM_HOLD;
    if (!skip_q) begin
      if (too_fast && trim_q != '0)           dir = TRIM_DOWN;
      else if (too_slow && trim_q != TRIM_MAX) dir = TRIM_UP;
    end
  end

  always_comb begin
    trim_d = trim_q;
    skip_d = skip_q;
    if (!en_i) begin
      skip_d = 1'b0;
    end else if (win_end_i) begin
      skip_d = (dir != TRIM_HOLD);
      case (dir)
        TRIM_UP:   trim_d = trim_q + 1'b1;
        TRIM_DOWN: trim_d = trim_q - 1'b1;
        default:   trim_d = trim_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= TRIM_INIT;
      skip_q <= 1'b0;
      meas_q <= '0;
    end else begin
      trim_q <= trim_d;
      skip_q <= skip_d;
      if (win_end_i) meas_q <= win_cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      up_q   <= 1'b0;
      down_q <= 1'b0;
    end else begin
      done_q <= win_end_i;
      up_q   <= win_end_i && (dir == TRIM_UP);
      down_q <= win_end_i && (dir == TRIM_DOWN);
    end
  end

  assign trim_o = trim_q;
  assign done_o = done_q;
  assign up_o   = up_q;
  assign down_o = down_q;
  assign meas_o = meas_q;
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int CNT_W       = 16,
  parameter int TRIM_W      = 6,
  parameter int TRIM_RST    = 32,
  parameter int REF_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ref_clk_i,
  input  logic [CNT_W-1:0]  expect_i,
  input  logic [CNT_W-1:0]  tol_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              done_o,
  output logic              up_o,
  output logic              down_o,
  output logic [CNT_W-1:0]  meas_o
);
  logic             ref_rise;
  logic             win_end;
  logic [CNT_W-1:0] win_cnt;

  ots_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_async_i(ref_clk_i), .ref_rise_o(ref_rise)
  );

  ots_window #(.CNT_W(CNT_W), .REF_EDGES(REF_EDGES)) u_win (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ref_rise_i(ref_rise),
    .win_end_o(win_end), .win_cnt_o(win_cnt)
  );

  ots_trim_ctl #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .win_end_i(win_end),
    .win_cnt_i(win_cnt), .expect_i(expect_i), .tol_i(tol_i),
    .trim_o(trim_o), .done_o(done_o), .up_o(up_o), .down_o(down_o),
    .meas_o(meas_o)
  );
endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk #(
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [TRIM_W-1:0] trim_o,
  input logic              done_o,
  input logic              up_o,
  input logic              down_o
);
  localparam logic [TRIM_W-1:0] MAXV = '1;

  logic adj_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       adj_pend_q <= 1'b0;
    else if (!en_i)                   adj_pend_q <= 1'b0;
    else if (up_o || down_o)          adj_pend_q <= 1'b1;
    else if (done_o)                  adj_pend_q <= 1'b0;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_flag_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o || down_o) |-> done_o);
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && down_o));
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    down_o |-> (trim_o == TRIM_W'($past(trim_o) - 1'b1)));
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_o |-> (trim_o == TRIM_W'($past(trim_o) + 1'b1)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o || down_o) |-> $stable(trim_o));
  p_no_wrap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_o == MAXV) |=> (trim_o != '0));
  p_no_wrap_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_o == '0) |=> (trim_o != MAXV));
  p_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && adj_pend_q) |-> !(up_o || down_o));
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !done_o);
endmodule

bind osc_trim_ctrl osc_trim_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .trim_o(trim_o),
  .done_o(done_o), .up_o(up_o), .down_o(down_o)
);

// File: tb/osc_trim_ctrl_bench.sv
module osc_trim_ctrl_bench;
  localparam int CW = 16;
  localparam int TW = 6;
  localparam int NE = 4;
  localparam int TMAX = 63;

  typedef struct packed {
    logic [7:0]  half;
    logic [15:0] expv;
    logic [15:0] tol;
  } vec_t;

  // half period of reference (sys cycles), expected count, tolerance
  localparam vec_t VECS [10] = '{
    '{8'd10, 16'd80,  16'd0},
    '{8'd10, 16'd100, 16'd5},
    '{8'd10, 16'd60,  16'd5},
    '{8'd10, 16'd85,  16'd5},
    '{8'd10, 16'd75,  16'd5},
    '{8'd10, 16'd74,  16'd5},
    '{8'd12, 16'd96,  16'd0},
    '{8'd12, 16'd200, 16'd10},
    '{8'd6,  16'd40,  16'd7},
    '{8'd15, 16'd121, 16'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          ref_clk;
  logic [CW-1:0] expv, tol;
  logic [TW-1:0] trim;
  logic          done, up, down;
  logic [CW-1:0] meas;

  int   n_total = 0;
  int   n_fail  = 0;
  int   m_trim;
  bit   m_skip;
  int   cur_p;
  int   ref_half = 10;
  int   gen_cnt  = 0;
  logic ref_gen  = 1'b0;
  logic ref_manual = 1'b0;
  logic ref_man_val = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (gen_cnt >= ref_half - 1) begin
      gen_cnt <= 0;
      ref_gen <= ~ref_gen;
    end else begin
      gen_cnt <= gen_cnt + 1;
    end
  end
  assign ref_clk = ref_manual ? ref_man_val : ref_gen;

  osc_trim_ctrl u_osc_trim_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ref_clk_i(ref_clk),
    .expect_i(expv), .tol_i(tol), .trim_o(trim), .done_o(done),
    .up_o(up), .down_o(down), .meas_o(meas)
  );

  task automatic check(input bit ok, input string req, input int act, input int expct);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expct);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart(input int half, input int e, input int t);
    en = 1'b0;
    expv = CW'(e);
    tol  = CW'(t);
    ref_half = half;
    cur_p = 2 * half * NE;
    cycles(200);
    m_skip = 1'b0;
    en = 1'b1;
  endtask

  // wait for one strobe and compare against the requirement model
  task automatic check_window();
    int waited = 0;
    int exp_dir;
    int act_dir;
    string tag;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      check(1'b0, "R2 strobe timeout", 0, 1);
      return;
    end
    exp_dir = 0;
    tag = "R5";
    if (m_skip) begin
      m_skip = 1'b0;
      tag = "R7";
    end else if (cur_p > int'(expv) + int'(tol)) begin
      if (m_trim > 0) begin exp_dir = 2; m_trim--; m_skip = 1'b1; tag = "R3"; end
      else tag = "R6";
    end else if (cur_p + int'(tol) < int'(expv)) begin
      if (m_trim < TMAX) begin exp_dir = 1; m_trim++; m_skip = 1'b1; tag = "R4"; end
      else tag = "R6";
    end
    act_dir = (up ? 1 : 0) + (down ? 2 : 0);
    check(int'(meas) == cur_p, "R2 measured count", int'(meas), cur_p);
    check(act_dir == exp_dir, {tag, " flags"}, act_dir, exp_dir);
    check(int'(trim) == m_trim, {tag, " trim code"}, int'(trim), m_trim);
    @(negedge clk);
    check(done == 1'b0, "R8 strobe width", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total + 1);
    $finish;
  end

  initial begin
    int dones;
    rst_n = 1'b0;
    en = 1'b0;
    expv = '0;
    tol = '0;
    cur_p = 80;
    m_skip = 1'b0;
    cycles(3);
    check(int'(trim) == 32, "R1 trim in reset", int'(trim), 32);
    check({done, up, down} == 3'b000, "R1 flags in reset", int'({done, up, down}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cycles(2);
    check(int'(trim) == 32 && meas == '0, "R1 after release", int'(trim), 32);
    m_trim = 32;

    // table walk: one fresh window per vector
    foreach (VECS[k]) begin
      restart(int'(VECS[k].half), int'(VECS[k].expv), int'(VECS[k].tol));
      check_window();
    end

    // settle window after adjustment (R7)
    restart(10, 200, 0);
    check_window();
    check_window();
    check_window();

    // saturation high (R6)
    restart(4, 200, 0);
    for (int g = 0; g < 200 && m_trim != TMAX; g++) check_window();
    check_window();
    check_window();
    check(int'(trim) == TMAX, "R6 top limit", int'(trim), TMAX);

    // saturation low (R6)
    restart(4, 10, 0);
    for (int g = 0; g < 200 && m_trim != 0; g++) check_window();
    check_window();
    check_window();
    check(int'(trim) == 0, "R6 bottom limit", int'(trim), 0);

    // disabled: no strobe, trim held (R10)
    restart(4, 100, 0);
    en = 1'b0;
    dones = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0, "R10 no strobe while disabled", dones, 0);
    check(int'(trim) == m_trim, "R10 trim held", int'(trim), m_trim);
    m_skip = 1'b0;
    en = 1'b1;
    check_window();

    // latency from closing reference edge (R9), ref driven by hand
    en = 1'b0;
    expv = 16'd40;
    tol = 16'd0;
    ref_manual = 1'b1;
    ref_man_val = 1'b0;
    cycles(10);
    en = 1'b1;
    m_skip = 1'b0;
    dones = 0;
    for (int r = 0; r < NE; r++) begin
      ref_man_val = 1'b1;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (done) dones++; end
      ref_man_val = 1'b0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (done) dones++; end
    end
    check(dones == 0, "R10 first edge only opens window", dones, 0);
    ref_man_val = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R9 edge 1", int'(done), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 edge 2", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R9 edge 3", int'(done), 1);
    check(int'(meas) == 40, "R2 manual window", int'(meas), 40);
    check(int'(trim) == m_trim && !up && !down, "R5 manual window hold", int'(trim), m_trim);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule